// File: doc/BRIEF.md
# Field Memory Read Port Controller

This block is the read half of a reset-addressed field memory used as a programmable video delay. It runs entirely in the serial read clock domain. A read-reset input returns the read address pointer to zero. A read-enable input lets the pointer advance or freezes it. An output-enable input decides whether the byte output is driven. The array sits outside the block: the controller presents an address, raises a one-cycle fetch request whenever that address changes, and registers the returned word onto the byte output.

The output models a three-state pin as a registered byte together with a registered drive flag. While the flag is low the byte reads as zero. Output-enable only qualifies the drive. The pointer keeps moving underneath it, so a stretch of words can be skipped. Read-enable, by contrast, freezes the pointer, and the last word stays on the output. A polarity-select input makes all three controls active-low, and it leaves the data untouched.

A sticky protocol-error flag catches two misuses of the reset protocol. The first is a read-reset that arrives too soon after the previous one, or too soon after block reset. The second is a read sequence that holds fewer active read cycles than the configured minimum before the next read-reset.

Top module: `fmr_read_port`

## Requirements
- R1: On a clock edge that samples read-reset active, the pointer becomes zero. Read-enable has no effect in that cycle, and output-enable has no effect either: the drive flag keeps its previous value.
- R2: Outside a reset cycle, an edge with read-enable active increments the pointer, and an edge with read-enable inactive leaves it unchanged. The pointer wraps from DEPTH-1 to 0.
- R3: On every edge the output register captures the memory word at the address presented before that edge. As a result, with read-enable inactive the output keeps showing the word of the held address.
- R4: The drive flag is output-enable as sampled on the previous non-reset edge. While the flag is 0, the byte output reads 0 and the pointer still advances with read-enable.
- R5: With cfg_active_low = 1, a control input is active when it is 0. With cfg_active_low = 0, a control input is active when it is 1. The data byte is never inverted.
- R6: mem_req_o is 1 for the cycle that follows every edge on which the pointer was loaded, either by a reset or by an increment. It is 0 after an edge that held the pointer.
- R7: A read-reset sampled when fewer than two consecutive inactive read-reset samples precede it, counted since the last active sample or since block reset, sets proto_err_o.
- R8: A read-reset that closes a sequence opened by an earlier read-reset sets proto_err_o if that sequence held fewer than MIN_RUN cycles with read-enable and output-enable both active. The reset cycle itself is not counted.
- R9: proto_err_o stays 1 until block reset. An asynchronous low on rst_n clears the pointer, mem_req_o, the output byte, the drive flag and proto_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial read clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| cfg_active_low | input | 1 | Polarity select for the three controls |
| rd_rst_i | input | 1 | Read-reset control |
| rd_en_i | input | 1 | Read-enable control |
| out_en_i | input | 1 | Output-enable control |
| mem_addr_o | output | $clog2(DEPTH) | Read address pointer |
| mem_req_o | output | 1 | Fetch request after the address changes |
| mem_data_i | input | DW | Word returned by the array at mem_addr_o |
| dout_o | output | DW | Registered data byte, zero while not driven |
| dout_drive_o | output | 1 | Drive flag (output not floating) |
| proto_err_o | output | 1 | Sticky reset-protocol error |

## Verification
The short-sequence error is the hardest case to reach alone. A read-reset that comes too early also closes a sequence that is too short, so the two error causes usually fire together. The stimulus separates them in two steps. First it issues a read-reset on the very first cycle after block reset, when no sequence is open yet, which exposes only the spacing rule. Then, in a fresh run with proper spacing, it closes a sequence after three active reads to expose only the length rule. A second hard case is output-enable gating with the pointer still running. The vector table covers it by floating the output while the pointer advances, then checking that the word which appears afterwards comes from the advanced address.

// File: rtl/fmr_pkg.sv
package fmr_pkg;

  typedef struct packed {
    logic rst;  // read-reset sampled active
    logic adv;  // pointer advance (never together with rst)
    logic drv;  // output-enable sampled active
  } fmr_ctl_t;

  // map a pin level to its logical meaning under the polarity select
  function automatic logic pin_active(input logic pin, input logic low_true);
    return pin ^ low_true;
  endfunction

endpackage

// File: rtl/fmr_ctl_decode.sv
module fmr_ctl_decode
  import fmr_pkg::*;
(
  input  logic     low_true,
  input  logic     rst_pin,
  input  logic     en_pin,
  input  logic     oe_pin,
  output fmr_ctl_t ctl
);
  logic rst_a, en_a, oe_a;

  assign rst_a   = pin_active(rst_pin, low_true);
  assign en_a    = pin_active(en_pin, low_true);
  assign oe_a    = pin_active(oe_pin, low_true);
  assign ctl.rst = rst_a;
  assign ctl.adv = en_a & ~rst_a;
  assign ctl.drv = oe_a;
endmodule

// File: rtl/fmr_rd_ptr.sv
module fmr_rd_ptr
  import fmr_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmr_ctl_t      ctl,
  output logic [AW-1:0] ptr,
  output logic          req
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      req <= 1'b0;
    end else begin
      req <= ctl.rst | ctl.adv;
      if (ctl.rst)      ptr <= '0;
      else if (ctl.adv) ptr <= step_ptr(ptr);
    end
  end
endmodule

// File: rtl/fmr_out_stage.sv
module fmr_out_stage
  import fmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmr_ctl_t      ctl,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] dout,
  output logic          drive
);
  logic [DW-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      drive  <= 1'b0;
    end else begin
      word_q <= word_i;
      if (!ctl.rst) drive <= ctl.drv;
    end
  end

  assign dout = drive ? word_q : '0;
endmodule

// File: rtl/fmr_proto_mon.sv
module fmr_proto_mon
  import fmr_pkg::*;
#(
  parameter int MIN_RUN = 140,
  localparam int CW = $clog2(MIN_RUN + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  fmr_ctl_t ctl,
  output logic     spacing_evt,
  output logic     short_evt,
  output logic     err
);
  localparam logic [CW-1:0] RUN_MAX = CW'(MIN_RUN);

  logic [1:0]    gap_q;
  logic [CW-1:0] run_q;
  logic          open_q;
  logic          counted;

  function automatic logic run_short(input logic [CW-1:0] n);
    return n < RUN_MAX;
  endfunction

  assign counted     = ctl.adv & ctl.drv;
  assign spacing_evt = ctl.rst & (gap_q != 2'd2);
  assign short_evt   = ctl.rst & open_q & run_short(run_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 2'd0;
      run_q  <= '0;
      open_q <= 1'b0;
      err    <= 1'b0;
    end else begin
      err <= err | spacing_evt | short_evt;
      if (ctl.rst) begin
        gap_q  <= 2'd0;
        run_q  <= '0;
        open_q <= 1'b1;
      end else begin
        if (gap_q != 2'd2) gap_q <= gap_q + 2'd1;
        if (counted && run_q != RUN_MAX) run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fmr_read_port.sv
module fmr_read_port
  import fmr_pkg::*;
#(
  parameter int DW = 8,
  parameter int DEPTH = 1024,
  parameter int MIN_RUN = 140,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_active_low,
  input  logic          rd_rst_i,
  input  logic          rd_en_i,
  input  logic          out_en_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_req_o,
  input  logic [DW-1:0] mem_data_i,
  output logic [DW-1:0] dout_o,
  output logic          dout_drive_o,
  output logic          proto_err_o
);
  fmr_ctl_t ctl;
  logic     rst_hit, adv_hit, oe_act;
  logic     spacing_evt, short_evt;

  fmr_ctl_decode dec_i (
    .low_true(cfg_active_low),
    .rst_pin (rd_rst_i),
    .en_pin  (rd_en_i),
    .oe_pin  (out_en_i),
    .ctl     (ctl)
  );

  assign rst_hit = ctl.rst;
  assign adv_hit = ctl.adv;
  assign oe_act  = ctl.drv;

  fmr_rd_ptr #(.DEPTH(DEPTH)) ptr_i (
    .clk  (clk),
    .rst_n(rst_n),
    .ctl  (ctl),
    .ptr  (mem_addr_o),
    .req  (mem_req_o)
  );

  fmr_out_stage #(.DW(DW)) out_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .word_i(mem_data_i),
    .dout  (dout_o),
    .drive (dout_drive_o)
  );

  fmr_proto_mon #(.MIN_RUN(MIN_RUN)) mon_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .spacing_evt(spacing_evt),
    .short_evt  (short_evt),
    .err        (proto_err_o)
  );
endmodule

// File: rtl/fmr_read_port_chk.sv
module fmr_read_port_chk #(
  parameter int DW = 8,
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_hit,
  input logic          adv_hit,
  input logic          oe_act,
  input logic          spacing_evt,
  input logic          short_evt,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_req_o,
  input logic [DW-1:0] mem_data_i,
  input logic [DW-1:0] dout_o,
  input logic          dout_drive_o,
  input logic          proto_err_o
);
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> mem_addr_o == '0);

  assert_drive_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> $stable(dout_drive_o));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_hit && !adv_hit) |=> $stable(mem_addr_o));

  assert_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_hit |=> !$stable(mem_addr_o));

  assert_word_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!dout_drive_o || dout_o == $past(mem_data_i)));

  assert_drive_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_hit |=> dout_drive_o == $past(oe_act));

  assert_float_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_drive_o |-> dout_o == '0);

  assert_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_hit || adv_hit) |=> mem_req_o);

  assert_noreq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_hit && !adv_hit) |=> !mem_req_o);

  assert_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spacing_evt |=> proto_err_o);

  assert_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
    short_evt |=> proto_err_o);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o);
endmodule

bind fmr_read_port fmr_read_port_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_hit     (rst_hit),
  .adv_hit     (adv_hit),
  .oe_act      (oe_act),
  .spacing_evt (spacing_evt),
  .short_evt   (short_evt),
  .mem_addr_o  (mem_addr_o),
  .mem_req_o   (mem_req_o),
  .mem_data_i  (mem_data_i),
  .dout_o      (dout_o),
  .dout_drive_o(dout_drive_o),
  .proto_err_o (proto_err_o)
);

// File: tb/fmr_read_port_tb.sv
module fmr_read_port_tb_top;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int MIN_RUN = 6;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_active_low = 1'b0;
  logic          rd_rst_i = 1'b0, rd_en_i = 1'b0, out_en_i = 1'b0;
  logic [AW-1:0] mem_addr_o;
  logic          mem_req_o;
  logic [DW-1:0] mem_data_i;
  logic [DW-1:0] dout_o;
  logic          dout_drive_o;
  logic          proto_err_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  // array model: word content is a fixed function of the address
  function automatic logic [DW-1:0] word_at(input int a);
    return DW'(a * 17 + 3);
  endfunction

  assign mem_data_i = word_at(int'(mem_addr_o));

  fmr_read_port #(.DW(DW), .DEPTH(DEPTH), .MIN_RUN(MIN_RUN)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_active_low(cfg_active_low),
    .rd_rst_i      (rd_rst_i),
    .rd_en_i       (rd_en_i),
    .out_en_i      (out_en_i),
    .mem_addr_o    (mem_addr_o),
    .mem_req_o     (mem_req_o),
    .mem_data_i    (mem_data_i),
    .dout_o        (dout_o),
    .dout_drive_o  (dout_drive_o),
    .proto_err_o   (proto_err_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // logical levels in; pins driven per polarity; sampled at the next negedge
  task automatic cyc(input logic r, input logic e, input logic o);
    rd_rst_i = r ^ cfg_active_low;
    rd_en_i  = e ^ cfg_active_low;
    out_en_i = o ^ cfg_active_low;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic block_reset(input logic low_true);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_active_low = low_true;
    rd_rst_i = low_true;
    rd_en_i  = low_true;
    out_en_i = low_true;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 reset addr", int'(mem_addr_o), 0);
    check("R9 reset drive", int'(dout_drive_o), 0);
    check("R9 reset dout", int'(dout_o), 0);
    check("R9 reset err", int'(proto_err_o), 0);
    check("R9 reset req", int'(mem_req_o), 0);
    @(negedge clk);
  endtask

  // {rst, en, oe, exp_addr[4:0], exp_drive}
  localparam int NV = 15;
  localparam logic [8:0] VEC [NV] = '{
    9'b0_0_0_00000_0,
    9'b0_0_0_00000_0,
    9'b1_1_1_00000_0,
    9'b0_1_1_00001_1,
    9'b0_1_1_00010_1,
    9'b0_0_1_00010_1,
    9'b0_0_1_00010_1,
    9'b0_1_0_00011_0,
    9'b0_1_0_00100_0,
    9'b0_1_1_00101_1,
    9'b0_1_1_00110_1,
    9'b0_1_1_00111_1,
    9'b0_1_1_01000_1,
    9'b1_0_0_00000_1,
    9'b0_0_1_00000_1
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int prev_addr;
    block_reset(1'b0);

    // table walk: R1 R2 R3 R4 R6 under active-high controls
    prev_addr = 0;
    for (int i = 0; i < NV; i++) begin
      logic r, e, o, d;
      int a;
      r = VEC[i][8];
      e = VEC[i][7];
      o = VEC[i][6];
      a = int'(VEC[i][5:1]);
      d = VEC[i][0];
      cyc(r, e, o);
      check($sformatf("R1 R2 addr v%0d", i), int'(mem_addr_o), a);
      check($sformatf("R4 drive v%0d", i), int'(dout_drive_o), int'(d));
      check($sformatf("R3 dout v%0d", i), int'(dout_o), d ? int'(word_at(prev_addr)) : 0);
      check($sformatf("R6 req v%0d", i), int'(mem_req_o), int'(r | e));
      check($sformatf("R8 no err v%0d", i), int'(proto_err_o), 0);
      prev_addr = a;
    end

    // R2 wrap from DEPTH-1 to 0
    block_reset(1'b0);
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    cyc(1, 0, 0);
    for (int k = 0; k < DEPTH - 1; k++) cyc(0, 1, 1);
    check("R2 top addr", int'(mem_addr_o), DEPTH - 1);
    cyc(0, 1, 1);
    check("R2 wrap addr", int'(mem_addr_o), 0);
    check("R3 word before wrap", int'(dout_o), int'(word_at(DEPTH - 1)));
    cyc(0, 0, 0);
    cyc(1, 0, 0);
    check("R8 long run no err", int'(proto_err_o), 0);

    // R5 active-low controls, data not inverted
    block_reset(1'b1);
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    cyc(1, 1, 1);
    check("R5 low reset addr", int'(mem_addr_o), 0);
    cyc(0, 1, 1);
    check("R5 low advance addr", int'(mem_addr_o), 1);
    check("R5 low drive", int'(dout_drive_o), 1);
    check("R5 data polarity", int'(dout_o), int'(word_at(0)));
    cyc(0, 0, 1);
    check("R5 low hold addr", int'(mem_addr_o), 1);
    check("R5 held word", int'(dout_o), int'(word_at(1)));
    cyc(0, 0, 0);
    check("R5 low float", int'(dout_drive_o), 0);
    check("R5 low float dout", int'(dout_o), 0);

    // R7 spacing: read-reset on first cycle after block reset
    block_reset(1'b0);
    cyc(1, 1, 1);
    check("R7 early reset err", int'(proto_err_o), 1);
    check("R1 early reset addr", int'(mem_addr_o), 0);

    // R8 short sequence, then R9 sticky
    block_reset(1'b0);
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    cyc(1, 0, 0);
    cyc(0, 1, 1);
    cyc(0, 1, 1);
    cyc(0, 1, 1);
    cyc(0, 1, 0);
    cyc(0, 0, 0);
    check("R8 open seq no err", int'(proto_err_o), 0);
    cyc(1, 0, 0);
    check("R8 short seq err", int'(proto_err_o), 1);
    cyc(0, 0, 0);
    cyc(0, 1, 1);
    cyc(0, 0, 0);
    check("R9 err sticky", int'(proto_err_o), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule